// File: doc/BRIEF.md
# Motion Awake State Tracker

This block keeps a single awake/asleep state for a motion-sensing front end. One-cycle detect pulses come in from the threshold logic. An activity pulse wakes the state and an inactivity pulse puts it to sleep. Each accepted event also sets a sticky flag of its own kind. Both detectors run at once, so no host action is needed after the block is configured.

In loop mode the detectors take turns. While the block is awake, only inactivity can be accepted. While it is asleep, only activity can be accepted. Each accepted event clears the flag of the other kind, so interrupts re-arm with no host access.

There are two interrupt pins. Each pin selects one of four sources: a constant low, the activity flag, the inactivity flag or the awake level. The selected value then passes through an inversion bit. With the awake level selected, a pin acts as a motion-controlled power switch for downstream logic.

Top module: `motion_awake_tracker`

## Requirements
- R1: An accepted activity pulse makes `awake` 1 and sets `act_flag`, both visible after the clock edge that samples the pulse.
- R2: An accepted inactivity pulse makes `awake` 0 and sets `inact_flag`. If both pulses are accepted in the same cycle, `awake` becomes 1 and both flags are set.
- R3: After reset, `awake` is 1, and `act_flag` and `inact_flag` are 0.
- R4: When `loop_en` is 0, each flag stays set until a `status_rd` strobe. An event that arrives in the same cycle as the strobe sets its flag, and the set wins over the clear.
- R5: A `status_rd` strobe in a cycle with no accepted event clears both flags at the next edge and leaves `awake` unchanged.
- R6: When `loop_en` is 1, activity is accepted only while `awake` is 0 and inactivity only while `awake` is 1. A pulse that is not accepted changes neither the state nor any flag.
- R7: When `loop_en` is 1, an accepted activity clears `inact_flag`, and an accepted inactivity clears `act_flag`, in the same edge that sets the new flag.
- R8: The pin select codes are 0 = constant 0, 1 = `act_flag`, 2 = `inact_flag` and 3 = `awake`. The chosen value is XORed with the pin's invert bit, and the pin follows its select and invert inputs with no clock delay.
- R9: The two pins are selected and inverted independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_pulse | input | 1 | Activity detect pulse |
| inact_pulse | input | 1 | Inactivity detect pulse |
| loop_en | input | 1 | Alternating auto-clear mode |
| status_rd | input | 1 | Status read strobe, clears flags |
| pin1_sel | input | 2 | Source select for pin 1 |
| pin1_inv | input | 1 | Invert pin 1 |
| pin2_sel | input | 2 | Source select for pin 2 |
| pin2_inv | input | 1 | Invert pin 2 |
| awake | output | 1 | Awake state |
| act_flag | output | 1 | Latched activity flag |
| inact_flag | output | 1 | Latched inactivity flag |
| int_pin1 | output | 1 | Interrupt pin 1 |
| int_pin2 | output | 1 | Interrupt pin 2 |

## Verification
The hardest cases to reach are pulses that loop mode must ignore. One is an inactivity pulse while the block is already asleep. Another is a pair of simultaneous pulses where only one detector is armed. A third is a read strobe that coincides with a new event. The vector table first brings the block to sleep and awake in plain mode. It then switches to loop mode while the block is asleep, so that the first pulse presented there is one that must be ignored. Finally it presents both pulses together while the block is awake.

// File: rtl/motion_awake_tracker.sv
module motion_awake_tracker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_pulse,
  input  logic       inact_pulse,
  input  logic       loop_en,
  input  logic       status_rd,
  input  logic [1:0] pin1_sel,
  input  logic       pin1_inv,
  input  logic [1:0] pin2_sel,
  input  logic       pin2_inv,
  output logic       awake,
  output logic       act_flag,
  output logic       inact_flag,
  output logic       int_pin1,
  output logic       int_pin2
);

  logic act_take, inact_take;

  assign act_take   = act_pulse   && (!loop_en || !awake);
  assign inact_take = inact_pulse && (!loop_en ||  awake);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      awake      <= 1'b1;
      act_flag   <= 1'b0;
      inact_flag <= 1'b0;
    end else begin
      if (act_take)        awake <= 1'b1;
      else if (inact_take) awake <= 1'b0;
      act_flag   <= act_take   || (act_flag   && !status_rd && !(loop_en && inact_take));
      inact_flag <= inact_take || (inact_flag && !status_rd && !(loop_en && act_take));
    end
  end

  function automatic logic pick(input logic [1:0] sel, input logic inv,
                                input logic a, input logic f_act, input logic f_inact);
    logic v;
    case (sel)
      2'd0:    v = 1'b0;
      2'd1:    v = f_act;
      2'd2:    v = f_inact;
      default: v = a;
    endcase
    return v ^ inv;
  endfunction

  assign int_pin1 = pick(pin1_sel, pin1_inv, awake, act_flag, inact_flag);
  assign int_pin2 = pick(pin2_sel, pin2_inv, awake, act_flag, inact_flag);

  a_r1_act_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pulse && (!loop_en || !awake)) |=> (awake && act_flag));

  a_r2_inact_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (inact_pulse && !act_pulse && (!loop_en || awake)) |=> (!awake && inact_flag));

  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !status_rd && !act_pulse && !inact_pulse) |=> ($stable(act_flag) && $stable(inact_flag)));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !act_pulse && !inact_pulse) |=> (!act_flag && !inact_flag && $stable(awake)));

  a_r6_loop_ignore_act: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && awake && !inact_pulse) |=> awake);

  a_r7_loop_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && act_pulse && !awake) |=> !inact_flag);

endmodule

// File: tb/motion_awake_tracker_tb.sv
module motion_awake_tracker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_pulse = 1'b0, inact_pulse = 1'b0, loop_en = 1'b0, status_rd = 1'b0;
  logic [1:0] pin1_sel = 2'd3, pin2_sel = 2'd1;
  logic pin1_inv = 1'b0, pin2_inv = 1'b1;
  logic awake, act_flag, inact_flag, int_pin1, int_pin2;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  motion_awake_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .act_pulse(act_pulse), .inact_pulse(inact_pulse),
    .loop_en(loop_en), .status_rd(status_rd), .pin1_sel(pin1_sel), .pin1_inv(pin1_inv),
    .pin2_sel(pin2_sel), .pin2_inv(pin2_inv), .awake(awake), .act_flag(act_flag),
    .inact_flag(inact_flag), .int_pin1(int_pin1), .int_pin2(int_pin2));

  // {act, inact, loop, rd, exp_awake, exp_act, exp_inact}
  localparam int NV = 13;
  localparam logic [6:0] VEC [NV] = '{
    7'b0100_001, // R2 sleep
    7'b1000_111, // R1 wake
    7'b0000_111, // R4 hold
    7'b0001_100, // R5 read clears
    7'b1100_111, // R2 tie
    7'b0101_001, // R4 set beats read
    7'b0001_000, // R5
    7'b0110_000, // R6 inact ignored while asleep
    7'b1010_110, // R6 act accepted
    7'b1010_110, // R6 act ignored while awake
    7'b0110_001, // R7 act flag cleared
    7'b1010_110, // R7 inact flag cleared
    7'b1110_001  // R6 both: only inact armed
  };

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic model_pin(input logic [1:0] s, input logic inv,
                                     input logic a, input logic fa, input logic fi);
    logic v;
    v = (s == 2'd0) ? 1'b0 : (s == 2'd1) ? fa : (s == 2'd2) ? fi : a;
    return v ^ inv;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R3 reset state", {awake, act_flag, inact_flag}, 3'b100);
    chk("R8 pins after reset", {1'b0, int_pin1, int_pin2}, 3'b011);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {act_pulse, inact_pulse, loop_en, status_rd} = VEC[i][6:3];
      @(posedge clk);
      #1;
      chk($sformatf("R1/R2/R4-R7 vector %0d", i), {awake, act_flag, inact_flag}, VEC[i][2:0]);
      chk($sformatf("R8 pins vector %0d", i), {1'b0, int_pin1, int_pin2},
          {1'b0, VEC[i][2], ~VEC[i][1]});
    end
    @(negedge clk);
    {act_pulse, inact_pulse, loop_en, status_rd} = 4'b0000;

    // state now: awake 0, act 0, inact 1; R8 and R9 sweep, combinational
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        pin1_sel = 2'(s); pin1_inv = p[0];
        pin2_sel = 2'(3 - s); pin2_inv = ~p[0];
        #1;
        chk($sformatf("R8 R9 sel %0d inv %0d", s, p),
            {1'b0, int_pin1, int_pin2},
            {1'b0, model_pin(2'(s), p[0], 1'b0, 1'b0, 1'b1),
                   model_pin(2'(3 - s), ~p[0], 1'b0, 1'b0, 1'b1)});
      end
    end

    // R3 reset in mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R3 reset mid-run", {awake, act_flag, inact_flag}, 3'b100);

    // R4 long hold outside loop mode
    @(negedge clk) act_pulse = 1'b1;
    @(negedge clk) act_pulse = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 flag held over idle cycles", {awake, act_flag, inact_flag}, 3'b110);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule